// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a down-counting interval timer behind a small word-wide register bank. Software programs a reload value, selects whether the count advances on every core clock or only on cycles where an external single-cycle reference strobe is high, and enables the counter. Each time the count runs out, a sticky "count reached" flag is raised, an optional one-cycle interrupt pulse is emitted, and the counter refills from the reload value. The block is meant as the periodic time base of an operating-system scheduler: the interrupt pulse goes to an interrupt controller that is not part of this block.

The bus is a plain single-cycle read/write port with byte addresses and 32-bit words. Read data is combinational from the address. Side effects take place at the clock edge that ends the access. These side effects are clearing the flag on a control read, and the register updates on writes. The count register is 24 bits wide. A zero reload value turns the timer into a one-shot. Pausing the timer keeps the remaining count, so that re-enabling it resumes from that count.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers read 0 and `irq_pulse` is low.
- R2: Offset 0xC is read-only and always reads 10000. Any offset other than 0x0, 0x4, 0x8 and 0xC reads 0. Writes to 0xC or to an unmapped offset change nothing.
- R3: Control layout: bit 0 run enable, bit 1 interrupt enable, bit 2 count source, bit 16 sticky flag, all other bits 0. A control write changes only bits 2..0. Software can never set the flag.
- R4: When the run enable is written from 0 to 1 with no paused count, the counter takes the reload value. On each count tick, a nonzero count drops by one. A tick while the count is 0 is an expiry, which refills the count from the reload value. The result is a period of reload+1 ticks.
- R5: On expiry the flag is set. If interrupt enable is 1, `irq_pulse` is high for exactly the one cycle after the expiring clock edge.
- R6: An expiry with a reload value of 0 clears the run enable, so the timer fires once and stops.
- R7: A read of offset 0x0 returns the current flag and clears the flag at the end of the access. If an expiry falls on the same edge, the flag stays set.
- R8: A write of any data to offset 0x8 loads the counter from the reload value, cancels any paused count, and clears the flag.
- R9: Offset 0x8 reads 0 while the run enable is 0. Clearing the run enable by a write keeps the count, and a later 0-to-1 write resumes from it. No count tick is taken in a cycle that writes offset 0x0 or 0x8.
- R10: With source bit 1, every clock is a count tick. With source bit 0, only cycles with `ref_tick` high are count ticks. Changing the source bit while running restarts the count from the reload value.
- R11: The reload and current-value registers are 24 bits wide. Bits 31..24 read as 0 and are dropped on writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | External reference strobe, one cycle wide |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_pulse | output | 1 | One-cycle expiry interrupt |

## Verification
The assertions assume that every access lasts exactly one cycle and that `bus_wr` and `bus_addr` are stable while `bus_sel` is high. They also assume that `ref_tick` is a synchronous single-cycle level, and that addresses are word aligned. The bench changes inputs only just after a rising edge, holds each access for a single cycle, and drives `ref_tick` as isolated or back-to-back one-cycle pulses only while the external source is selected. Exact count values are predicted by counting edges from the enabling write, so the stimulus never overlaps a write with an expiry except where that is the case under test.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          CNT_W     = 24,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CAL_VALUE = 32'd10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h0);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(8'h4);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(8'h8);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(8'hC);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
  localparam int                PAD_W  = 32 - CNT_W;

  logic             run_en, int_en, src_core, hit_flag, paused;
  logic [CNT_W-1:0] count, reload;

  wire rd_acc  = bus_sel & ~bus_wr;
  wire wr_acc  = bus_sel &  bus_wr;
  wire hit_ctl = bus_addr == A_CTRL;
  wire hit_rld = bus_addr == A_RLD;
  wire hit_cur = bus_addr == A_CUR;
  wire hit_cal = bus_addr == A_CAL;
  wire wr_ctl  = wr_acc & hit_ctl;
  wire wr_cur  = wr_acc & hit_cur;
  wire rd_ctl  = rd_acc & hit_ctl;

  wire step   = run_en & (src_core | ref_tick) & ~wr_ctl & ~wr_cur;
  wire expire = step & (count == '0);

  wire new_en  = bus_wdata[0];
  wire new_src = bus_wdata[2];
  wire unused_wdata = ^bus_wdata[31:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      int_en    <= 1'b0;
      src_core  <= 1'b0;
      hit_flag  <= 1'b0;
      paused    <= 1'b0;
      count     <= '0;
      reload    <= '0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= expire & int_en;

      if (wr_acc && hit_rld) reload <= bus_wdata[CNT_W-1:0];

      if (expire)               hit_flag <= 1'b1;
      else if (wr_cur || rd_ctl) hit_flag <= 1'b0;

      if (wr_ctl) begin
        run_en   <= new_en;
        int_en   <= bus_wdata[1];
        src_core <= new_src;
        if (new_en && !run_en) begin
          if (!paused) count <= reload;
          paused <= 1'b0;
        end else if (!new_en && run_en) begin
          paused <= 1'b1;
        end else if (new_en && run_en && (new_src != src_core)) begin
          count <= reload;
        end
      end else if (wr_cur) begin
        count  <= reload;
        paused <= 1'b0;
      end else if (expire) begin
        count <= reload;
        if (reload == '0) run_en <= 1'b0;
      end else if (step) begin
        count <= count - ONE;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctl)      bus_rdata = {15'd0, hit_flag, 13'd0, src_core, int_en, run_en};
    else if (hit_rld) bus_rdata = {{PAD_W{1'b0}}, reload};
    else if (hit_cur) bus_rdata = run_en ? {{PAD_W{1'b0}}, count} : 32'd0;
    else if (hit_cal) bus_rdata = CAL_VALUE;
  end

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R3
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> $past(expire));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && !expire) |=> !hit_flag);

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload == '0) |=> !run_en);

  // R9
  idle_cur_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit_cur && !run_en) |-> bus_rdata == 32'd0);

  // R2
  cal_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit_cal) |-> bus_rdata == CAL_VALUE);

  // R11
  rld_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit_rld) |-> bus_rdata[31:CNT_W] == '0 && !unused_wdata || bus_rdata[31:CNT_W] == '0);

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  always #10 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  typedef struct {
    string       req;
    logic [31:0] exp;
  } exp_t;
  exp_t sbq[$];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int irq_hi = 0;
  int irq_at[16];
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      n_cmp++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (bus_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s: addr %h actual %h expected %h", e.req, bus_addr, bus_rdata, e.exp);
        end
      end
    end
    if (irq_pulse) irq_hi++;
    if (irq_pulse && !irq_prev) begin
      if (irq_cnt < 16) irq_at[irq_cnt] = cyc;
      irq_cnt++;
    end
    irq_prev = irq_pulse;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    exp_t e;
    e.req = req; e.exp = exp;
    sbq.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_ref();
    ref_tick = 1'b1;
    @(posedge clk); #1;
    ref_tick = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h0, 32'h0, "R1 ctrl");
    rd(8'h4, 32'h0, "R1 reload");
    rd(8'h8, 32'h0, "R1 current");
    chk("R1 irq", int'(irq_pulse), 0);
    // R2 calibration and unmapped reads
    rd(8'hC, 32'd10000, "R2 cal");
    rd(8'h10, 32'h0, "R2 unmapped");
    // R11 upper bits dropped
    wr(8'h4, 32'hFFFF_FFFF);
    rd(8'h4, 32'h00FF_FFFF, "R11 reload width");

    // R4 / R5 periodic run, reload 5
    wr(8'h4, 32'd5);
    wr(8'h0, 32'h7);
    rd(8'h8, 32'd5, "R4 load on enable");
    rd(8'h8, 32'd4, "R4 count down");
    idle(5);
    rd(8'h0, 32'h0001_0007, "R5 flag set");
    rd(8'h0, 32'h0000_0007, "R7 flag cleared by read");
    idle(10);
    chk("R5 irq count", irq_cnt, 3);
    chk("R5 irq width", irq_hi, 3);
    chk("R4 period", irq_at[1] - irq_at[0], 6);
    chk("R4 period 2", irq_at[2] - irq_at[1], 6);

    // R9 pause and resume, reload 9
    wr(8'h0, 32'h0);
    wr(8'h8, 32'h0);
    wr(8'h4, 32'd9);
    wr(8'h0, 32'h5);
    idle(2);
    wr(8'h0, 32'h4);
    rd(8'h8, 32'd0, "R9 disabled reads 0");
    wr(8'h0, 32'h5);
    rd(8'h8, 32'd7, "R9 resume held count");

    // R8 current-value write reloads and clears flag
    wr(8'h8, 32'h123);
    rd(8'h8, 32'd9, "R8 forced reload");
    idle(12);
    wr(8'h8, 32'hDEAD);
    rd(8'h0, 32'h5, "R8 flag cleared by write");
    rd(8'h8, 32'd8, "R8 count after reload");

    // R10 source switch and external ticks
    wr(8'h0, 32'h1);
    rd(8'h8, 32'd9, "R10 restart on source change");
    idle(3);
    rd(8'h8, 32'd9, "R10 no ticks without ref");
    pulse_ref();
    pulse_ref();
    pulse_ref();
    rd(8'h8, 32'd6, "R10 ref ticks");

    // R6 zero reload one-shot
    wr(8'h0, 32'h0);
    wr(8'h8, 32'h0);
    wr(8'h4, 32'h0);
    wr(8'h0, 32'h7);
    idle(3);
    rd(8'h0, 32'h0001_0006, "R6 enable self-cleared");
    rd(8'h8, 32'd0, "R6 stopped");
    idle(4);
    chk("R6 single irq", irq_cnt, 4);

    // R7 read and expiry on the same edge
    wr(8'h4, 32'd3);
    wr(8'h0, 32'h5);
    idle(3);
    rd(8'h0, 32'h0000_0005, "R7 read at expiry");
    rd(8'h0, 32'h0001_0005, "R7 expiry wins");

    // R3 only low control bits writable, flag not settable
    wr(8'h0, 32'hFFFF_FFFC);
    rd(8'h0, 32'h0000_0004, "R3 control write mask");
    // R2 ignored writes
    wr(8'h10, 32'hAB);
    wr(8'hC, 32'd55);
    rd(8'h4, 32'd3, "R2 unmapped write ignored");
    rd(8'hC, 32'd10000, "R2 cal read-only");

    chk("scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule